// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the write-command state machine of a byte-wide parallel NOR flash. Each qualified write strobe brings an address and a data byte. The block matches these writes against multi-cycle unlock sequences. From them it starts embedded byte-program and erase operations, enters and leaves the identification mode, and suspends and resumes an erase. It also leaves a time-out state when told to. Any write that breaks a sequence sends it back to idle.

A small synchronous array model sits behind the interpreter. A read port returns one of three things, chosen by the current mode and the read address: array bytes, identification bytes, or a status byte. Two embedded-operation timers give the program and erase operations their duration. An injected stall input holds an operation so that the time-out path can be reached.

Top module: `flash_cmd_ctrl`

Mode codes on `dev_mode`:

| Code | Mode |
|------|------|
| 0 | array read |
| 1 | identification |
| 2 | programming |
| 3 | erasing |
| 4 | erase suspended |
| 5 | programming while suspended |
| 6 | identification while suspended |
| 7 | timed out |

Read source codes on `rd_src`:

| Code | Source |
|------|--------|
| 0 | array |
| 1 | ID |
| 2 | status |

## Requirements
- R1: After reset the block is in array read with no command needed: `dev_mode`=0, `busy`=0, `rd_src`=0.
- R2: Program, erase and identification commands are accepted only after the unlock pair: data 0xAA at address 0x555, then data 0x55 at address 0x2AA (the low 11 address bits are compared).
- R3: A byte program takes four writes: the unlock pair, 0xA0 at 0x555, then the target address and data. The block then shows mode 2 with `busy`=1. After PROG_CYC cycles the stored byte becomes the old byte AND the new data, so a bit can only be cleared.
- R4: A write with the wrong address or data for its place in a sequence returns the sequence to idle and starts nothing.
- R5: Data 0xF0 at any address, written between the cycles of a sequence, abandons the sequence. The mode is then array read, or erase suspended if the sequence began there.
- R6: While a program or erase runs, 0xF0 is ignored and the mode does not change.
- R7: The unlock pair followed by 0x90 at 0x555 enters identification: mode 1, or mode 6 from erase suspended. Reads then return, by address bits [1:0], 0 → MFR_ID, 1 → DEV_ID, 2 and 3 → 0x00, for any number of reads. Only 0xF0 leaves this mode, going to mode 0 or mode 4, and every other write is ignored.
- R8: In the timed-out mode (7), writing 0xF0 returns the block to array read.
- R9: In erase suspended mode (4), reads in the sector being erased return status (`rd_src`=2) and reads elsewhere return array data. A program started there shows mode 5 and returns to mode 4 when done. The same read rule holds afterwards.
- R10: When a program completes, the block returns to array read by itself.
- R11: Erase is six writes: the unlock pair, 0x80 at 0x555, the unlock pair again, then either 0x10 at 0x555 (whole array) or 0x30 at any address in the target sector. The sector is given by the top SECT_W address bits. The block shows mode 3 and writes 0xFF to one byte per cycle across the target. Other sectors are left unchanged.
- R12: 0xB0 during an erase enters mode 4 and holds the erase progress. 0x30 written in mode 4 resumes the erase (mode 3). 0xB0 written in array read is ignored.
- R13: While `stall_inj` is high, a running operation makes no progress. TMO_CYC cycles of busy time after its start, the block enters mode 7.
- R14: The status byte is built as follows:
  - bit 7 is the complement of data bit 7 of the program in progress or timed out, and 0 for an erase;
  - bit 6 is 0 on the first status read after reset and inverts on each status read;
  - bit 5 is set only in mode 7;
  - bits 4..0 are 0.
  Reads are returned one cycle after `rd_en`, together with `rd_src`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Qualified write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| stall_inj | input | 1 | Injected failure: holds embedded progress |
| rd_data | output | 8 | Read result, one cycle after `rd_en` |
| rd_src | output | 2 | Source of `rd_data`: 0 array, 1 ID, 2 status |
| dev_mode | output | 3 | Current mode code |
| busy | output | 1 | Program or erase running |

## Verification
The bench uses AW=11 and SECT_W=2, which gives four 512-byte sectors and a whole-array erase of 2048 cycles. It sets PROG_CYC=6, which leaves room to issue a reset write and a status read inside a single program. TMO_CYC=2600 stays above the whole-array erase, so the erase finishes normally, while a stalled program still reaches the timed-out mode within a few thousand cycles.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_AUTO  = 3'd1,
    M_PROG  = 3'd2,
    M_ERASE = 3'd3,
    M_SUSP  = 3'd4,
    M_SPROG = 3'd5,
    M_SAUTO = 3'd6,
    M_TMO   = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PSET, S_E1, S_E2, S_E3
  } seq_e;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_ID    = 2'd1,
    SRC_STAT  = 2'd2
  } src_e;

  localparam logic [10:0] A_UNL1   = 11'h555;
  localparam logic [10:0] A_UNL2   = 11'h2AA;
  localparam logic [7:0]  D_UNL1   = 8'hAA;
  localparam logic [7:0]  D_UNL2   = 8'h55;
  localparam logic [7:0]  C_PROG   = 8'hA0;
  localparam logic [7:0]  C_AUTO   = 8'h90;
  localparam logic [7:0]  C_RST    = 8'hF0;
  localparam logic [7:0]  C_ERS    = 8'h80;
  localparam logic [7:0]  C_CHIP   = 8'h10;
  localparam logic [7:0]  C_SECT   = 8'h30;
  localparam logic [7:0]  C_SUSP   = 8'hB0;
  localparam logic [7:0]  C_RESUME = 8'h30;

  function automatic logic bus_match(logic [10:0] a, logic [7:0] d,
                                     logic [10:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic [7:0] stat_byte(logic poll, logic tog, logic tmo);
    return {poll, tog, tmo, 5'b00000};
  endfunction

  function automatic logic [7:0] id_byte(logic [1:0] sel, logic [7:0] mfr,
                                         logic [7:0] dev);
    case (sel)
      2'd0:    return mfr;
      2'd1:    return dev;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_busy(mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_SPROG);
  endfunction

  function automatic src_e rd_source(mode_e m, logic susp_hit);
    case (m)
      M_READ:          return SRC_ARRAY;
      M_AUTO, M_SAUTO: return SRC_ID;
      M_SUSP:          return susp_hit ? SRC_STAT : SRC_ARRAY;
      default:         return SRC_STAT;
    endcase
  endfunction

endpackage

// File: rtl/flcmd_timer.sv
module flcmd_timer #(
  parameter int CW      = 11,
  parameter int TMO_CYC = 4096,
  localparam int AGW    = $clog2(TMO_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          stall,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] step_cnt,
  output logic          step_en,
  output logic          done,
  output logic          tmo
);

  logic [AGW-1:0] age;

  assign step_en = run && !stall;
  assign done    = step_en && (step_cnt == last);
  assign tmo     = run && !done && (age == AGW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      age      <= '0;
    end else if (start) begin
      step_cnt <= '0;
      age      <= '0;
    end else if (run) begin
      age <= age + 1'b1;
      if (step_en) step_cnt <= step_cnt + 1'b1;
    end
  end

  // R13: a running operation never outlives its time limit
  p_age_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (age < AGW'(TMO_CYC)));

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
  import flcmd_pkg::*;
#(
  parameter int AW     = 11,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              p_done,
  input  logic              p_tmo,
  input  logic              e_done,
  input  logic              e_tmo,
  output mode_e             mode,
  output logic              p_start,
  output logic              e_start,
  output logic [AW-1:0]     prog_addr,
  output logic [7:0]        prog_data,
  output logic              er_chip,
  output logic [SECT_W-1:0] er_sect,
  output logic              tmo_prog
);

  seq_e        sq, sq_n;
  mode_e       m_n;
  logic        chip_n;
  logic [10:0] a;

  assign a = wr_addr[10:0];

  always_comb begin
    m_n     = mode;
    sq_n    = sq;
    p_start = 1'b0;
    e_start = 1'b0;
    chip_n  = 1'b0;
    case (mode)
      M_READ, M_SUSP: begin
        if (wr_en) begin
          sq_n = S_IDLE;
          if (wr_data != C_RST) begin
            case (sq)
              S_IDLE: begin
                if (bus_match(a, wr_data, A_UNL1, D_UNL1)) sq_n = S_U1;
                else if (mode == M_SUSP && wr_data == C_RESUME) m_n = M_ERASE;
              end
              S_U1: if (bus_match(a, wr_data, A_UNL2, D_UNL2)) sq_n = S_U2;
              S_U2: begin
                if (a == A_UNL1) begin
                  if (wr_data == C_PROG) sq_n = S_PSET;
                  else if (wr_data == C_AUTO) m_n = (mode == M_READ) ? M_AUTO : M_SAUTO;
                  else if (wr_data == C_ERS && mode == M_READ) sq_n = S_E1;
                end
              end
              S_PSET: begin
                p_start = 1'b1;
                m_n     = (mode == M_READ) ? M_PROG : M_SPROG;
              end
              S_E1: if (bus_match(a, wr_data, A_UNL1, D_UNL1)) sq_n = S_E2;
              S_E2: if (bus_match(a, wr_data, A_UNL2, D_UNL2)) sq_n = S_E3;
              S_E3: begin
                if (bus_match(a, wr_data, A_UNL1, C_CHIP)) begin
                  e_start = 1'b1;
                  chip_n  = 1'b1;
                  m_n     = M_ERASE;
                end else if (wr_data == C_SECT) begin
                  e_start = 1'b1;
                  m_n     = M_ERASE;
                end
              end
              default: sq_n = S_IDLE;
            endcase
          end
        end
      end
      M_AUTO:  if (wr_en && wr_data == C_RST) m_n = M_READ;
      M_SAUTO: if (wr_en && wr_data == C_RST) m_n = M_SUSP;
      M_PROG: begin
        if (p_done) m_n = M_READ;
        else if (p_tmo) m_n = M_TMO;
      end
      M_SPROG: begin
        if (p_done) m_n = M_SUSP;
        else if (p_tmo) m_n = M_TMO;
      end
      M_ERASE: begin
        if (e_done) m_n = M_READ;
        else if (e_tmo) m_n = M_TMO;
        else if (wr_en && wr_data == C_SUSP) m_n = M_SUSP;
      end
      M_TMO:   if (wr_en && wr_data == C_RST) m_n = M_READ;
      default: m_n = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_READ;
      sq        <= S_IDLE;
      prog_addr <= '0;
      prog_data <= '0;
      er_chip   <= 1'b0;
      er_sect   <= '0;
      tmo_prog  <= 1'b0;
    end else begin
      mode <= m_n;
      sq   <= sq_n;
      if (p_start) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (e_start) begin
        er_chip <= chip_n;
        er_sect <= wr_addr[AW-1 -: SECT_W];
      end
      if (m_n == M_TMO && mode != M_TMO)
        tmo_prog <= (mode == M_PROG) || (mode == M_SPROG);
    end
  end

  // R2: programming cannot begin except from the set-up step
  p_prog_needs_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && !(sq == S_PSET && wr_en && wr_data != C_RST)) |=> (mode != M_PROG));

  // R4: a wrong second unlock cycle drops back to idle array read
  p_bad_unlock_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && sq == S_U1 && wr_en && !(a == A_UNL2 && wr_data == D_UNL2))
      |=> (sq == S_IDLE && mode == M_READ));

  // R5: reset between cycles abandons the sequence
  p_reset_in_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && sq != S_IDLE && wr_en && wr_data == C_RST)
      |=> (mode == M_READ && sq == S_IDLE));

  // R6: a running program holds its mode until done or timed out
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && !p_done && !p_tmo) |=> (mode == M_PROG));

  // R7: identification is left only through the reset command
  p_autosel_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AUTO && !(wr_en && wr_data == C_RST)) |=> (mode == M_AUTO));

  // R8: reset leaves the timed-out mode
  p_tmo_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TMO && wr_en && wr_data == C_RST) |=> (mode == M_READ));

  // R10: program completion returns to array read
  p_prog_done_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && p_done) |=> (mode == M_READ));

  // R12: suspend during an erase
  p_suspend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && !e_done && !e_tmo && wr_en && wr_data == C_SUSP) |=> (mode == M_SUSP));

endmodule

// File: rtl/flcmd_array.sv
module flcmd_array
  import flcmd_pkg::*;
#(
  parameter int AW   = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          we_and,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  input  src_e          src,
  input  logic [7:0]    idb,
  input  logic          poll,
  input  logic          tmo_flag,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_src
);

  logic [7:0] mem [DEPTH];
  logic       tog;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= we_and ? (mem[waddr] & wdata) : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_src  <= SRC_ARRAY;
      tog     <= 1'b0;
    end else if (rd_en) begin
      rd_src <= src;
      case (src)
        SRC_ARRAY: rd_data <= mem[raddr];
        SRC_ID:    rd_data <= idb;
        default: begin
          rd_data <= stat_byte(poll, tog, tmo_flag);
          tog     <= ~tog;
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flcmd_pkg::*;
#(
  parameter int         AW       = 11,
  parameter int         SECT_W   = 2,
  parameter int         PROG_CYC = 8,
  parameter int         TMO_CYC  = 4096,
  parameter logic [7:0] MFR_ID   = 8'h37,
  parameter logic [7:0] DEV_ID   = 8'hA4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          stall_inj,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_src,
  output logic [2:0]    dev_mode,
  output logic          busy
);

  localparam int SECT_AW = AW - SECT_W;

  mode_e             mode;
  logic              p_start, e_start, p_done, p_tmo, e_done, e_tmo;
  logic              p_step, e_step, er_chip, tmo_prog;
  logic [AW-1:0]     prog_addr, p_cnt, e_cnt, e_last, e_addr;
  logic [7:0]        prog_data;
  logic [SECT_W-1:0] er_sect;
  logic              susp_hit, poll;
  src_e              src;
  logic              we, we_and;
  logic [AW-1:0]     waddr;
  logic [7:0]        wdata;

  flcmd_seq #(.AW(AW), .SECT_W(SECT_W)) u_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .p_done, .p_tmo, .e_done, .e_tmo,
    .mode, .p_start, .e_start, .prog_addr, .prog_data,
    .er_chip, .er_sect, .tmo_prog
  );

  flcmd_timer #(.CW(AW), .TMO_CYC(TMO_CYC)) u_ptmr (
    .clk, .rst_n, .start(p_start),
    .run(mode == M_PROG || mode == M_SPROG), .stall(stall_inj),
    .last(AW'(PROG_CYC - 1)), .step_cnt(p_cnt), .step_en(p_step),
    .done(p_done), .tmo(p_tmo)
  );

  assign e_last = er_chip ? {AW{1'b1}} : {{SECT_W{1'b0}}, {SECT_AW{1'b1}}};

  flcmd_timer #(.CW(AW), .TMO_CYC(TMO_CYC)) u_etmr (
    .clk, .rst_n, .start(e_start), .run(mode == M_ERASE), .stall(stall_inj),
    .last(e_last), .step_cnt(e_cnt), .step_en(e_step),
    .done(e_done), .tmo(e_tmo)
  );

  assign e_addr = er_chip ? e_cnt : {er_sect, e_cnt[SECT_AW-1:0]};

  always_comb begin
    we     = 1'b0;
    we_and = 1'b0;
    waddr  = e_addr;
    wdata  = 8'hFF;
    if (p_done) begin
      we     = 1'b1;
      we_and = 1'b1;
      waddr  = prog_addr;
      wdata  = prog_data;
    end else if (e_step) begin
      we = 1'b1;
    end
  end

  assign susp_hit = er_chip || (rd_addr[AW-1 -: SECT_W] == er_sect);
  assign src      = rd_source(mode, susp_hit);
  assign poll     = (mode == M_PROG || mode == M_SPROG || (mode == M_TMO && tmo_prog))
                    ? ~prog_data[7] : 1'b0;

  flcmd_array #(.AW(AW)) u_arr (
    .clk, .rst_n, .we, .we_and, .waddr, .wdata,
    .rd_en, .raddr(rd_addr), .src,
    .idb(id_byte(rd_addr[1:0], MFR_ID, DEV_ID)),
    .poll, .tmo_flag(mode == M_TMO),
    .rd_data, .rd_src
  );

  assign dev_mode = mode;
  assign busy     = is_busy(mode);

  // R14: reads issued while busy come back as status
  p_busy_src_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_src == 2'(SRC_STAT)));

  // R6: erase ignores the reset command while running
  p_erase_ignores_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && !e_done && !e_tmo && wr_en && wr_data == C_RST) |=> (mode == M_ERASE));

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int AW = 11;
  localparam int PCYC = 6;
  localparam int TCYC = 2600;
  localparam logic [7:0] MFR = 8'h37;
  localparam logic [7:0] DEV = 8'hA4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, stall_inj = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] rd_src;
  logic [2:0] dev_mode;
  logic busy;

  flash_cmd_ctrl #(.AW(AW), .SECT_W(2), .PROG_CYC(PCYC), .TMO_CYC(TCYC),
                   .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .stall_inj,
    .rd_data, .rd_src, .dev_mode, .busy
  );

  int checks = 0, errors = 0;
  bit btog = 1'b0;
  logic [7:0] q_exp[$];
  logic [1:0] q_src[$];
  string q_tag[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unl();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp,
                    input logic [1:0] src, input string tag);
    logic [7:0] e;
    e = exp;
    if (src == 2'd2) begin
      e[6] = btog;
      btog = ~btog;
    end
    q_exp.push_back(e); q_src.push_back(src); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_mode(input logic [2:0] m, input int limit, input string tag);
    int n = 0;
    while (dev_mode !== m && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(dev_mode, m, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (q_exp.size() == 0) begin
          chk(1, 0, "monitor unexpected read");
        end else begin
          logic [7:0] e; logic [1:0] s; string t;
          e = q_exp.pop_front(); s = q_src.pop_front(); t = q_tag.pop_front();
          chk(rd_data, e, {t, " data"});
          chk(rd_src, s, {t, " src"});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dev_mode, 0, "R1 reset mode");
    chk(busy, 0, "R1 reset busy");
    chk(rd_src, 0, "R1 reset src");

    // R11 whole-array erase
    unl(); wr(11'h555, 8'h80); unl(); wr(11'h555, 8'h10);
    chk(dev_mode, 3, "R11 chip erase mode");
    chk(busy, 1, "R11 chip erase busy");
    wait_mode(0, 2100, "R11 chip erase finishes");
    rd(11'h000, 8'hFF, 0, "R11 erased low");
    rd(11'h7FF, 8'hFF, 0, "R11 erased high");

    // R3 program, R14 status, R6 reset ignored, R10 return
    unl(); wr(11'h555, 8'hA0); wr(11'h100, 8'h5A);
    chk(dev_mode, 2, "R3 program mode");
    chk(busy, 1, "R3 program busy");
    rd(11'h100, 8'h80, 2, "R14 program status");
    wr(11'h000, 8'hF0);
    chk(dev_mode, 2, "R6 reset ignored in program");
    repeat (PCYC) @(negedge clk);
    chk(dev_mode, 0, "R10 back to array read");
    rd(11'h100, 8'h5A, 0, "R3 programmed byte");
    unl(); wr(11'h555, 8'hA0); wr(11'h100, 8'h0F);
    wait_mode(0, 20, "R10 second program done");
    rd(11'h100, 8'h0A, 0, "R3 bits only clear");

    // R4 malformed sequences, R2 no program without unlock
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h200, 8'h77);
    chk(dev_mode, 0, "R4 bad unlock address");
    wr(11'h2AA, 8'h55); wr(11'h555, 8'hAA); wr(11'h555, 8'hA0); wr(11'h201, 8'h33);
    chk(dev_mode, 0, "R4 wrong order");
    wr(11'h555, 8'hA0); wr(11'h203, 8'h00);
    chk(dev_mode, 0, "R2 no unlock no program");
    rd(11'h200, 8'hFF, 0, "R4 untouched 200");
    rd(11'h201, 8'hFF, 0, "R4 untouched 201");
    rd(11'h203, 8'hFF, 0, "R2 untouched 203");

    // R5 reset between cycles
    unl(); wr(11'h555, 8'hA0); wr(11'h432, 8'hF0); wr(11'h202, 8'h11);
    chk(dev_mode, 0, "R5 reset aborts program");
    rd(11'h202, 8'hFF, 0, "R5 no write");

    // R7 identification
    unl(); wr(11'h555, 8'h90);
    chk(dev_mode, 1, "R7 enter id");
    rd(11'h000, MFR, 1, "R7 mfr");
    rd(11'h401, DEV, 1, "R7 dev");
    rd(11'h102, 8'h00, 1, "R7 prot");
    rd(11'h000, MFR, 1, "R7 repeat mfr");
    wr(11'h555, 8'hAA);
    chk(dev_mode, 1, "R7 other write ignored");
    wr(11'h333, 8'hF0);
    chk(dev_mode, 0, "R7 reset leaves id");
    rd(11'h100, 8'h0A, 0, "R7 array after id");

    // R12 suspend outside erase ignored
    wr(11'h000, 8'hB0);
    chk(dev_mode, 0, "R12 suspend ignored in read");

    // R9/R11/R12 sector erase with suspend
    unl(); wr(11'h555, 8'hA0); wr(11'h300, 8'h3C); wait_mode(0, 20, "R10 prep 300");
    unl(); wr(11'h555, 8'hA0); wr(11'h650, 8'hC3); wait_mode(0, 20, "R10 prep 650");
    unl(); wr(11'h555, 8'h80); unl(); wr(11'h300, 8'h30);
    chk(dev_mode, 3, "R11 sector erase mode");
    repeat (10) @(negedge clk);
    wr(11'h000, 8'hF0);
    chk(dev_mode, 3, "R6 reset ignored in erase");
    wr(11'h000, 8'hB0);
    chk(dev_mode, 4, "R12 suspended");
    repeat (600) @(negedge clk);
    chk(dev_mode, 4, "R12 progress held");
    rd(11'h300, 8'h00, 2, "R9 suspended sector status");
    rd(11'h100, 8'h0A, 0, "R9 other sector array");
    unl(); wr(11'h555, 8'hA0); wr(11'h651, 8'h81);
    chk(dev_mode, 5, "R9 program in suspend");
    wait_mode(4, 20, "R9 back to suspend");
    rd(11'h651, 8'h81, 0, "R9 suspended program result");
    rd(11'h310, 8'h00, 2, "R9 rule after program");
    unl(); wr(11'h555, 8'h90);
    chk(dev_mode, 6, "R7 id in suspend");
    rd(11'h001, DEV, 1, "R7 dev in suspend");
    wr(11'h000, 8'hF0);
    chk(dev_mode, 4, "R7 reset back to suspend");
    wr(11'h000, 8'h30);
    chk(dev_mode, 3, "R12 resumed");
    wait_mode(0, 600, "R11 sector erase finishes");
    rd(11'h300, 8'hFF, 0, "R11 sector wiped 300");
    rd(11'h3FF, 8'hFF, 0, "R11 sector wiped 3FF");
    rd(11'h650, 8'hC3, 0, "R11 other sector kept");
    rd(11'h100, 8'h0A, 0, "R11 sector 0 kept");

    // R13 time-out, R8 leave it
    stall_inj = 1'b1;
    unl(); wr(11'h555, 8'hA0); wr(11'h700, 8'h00);
    repeat (TCYC - 10) @(negedge clk);
    chk(dev_mode, 2, "R13 still busy before limit");
    repeat (20) @(negedge clk);
    chk(dev_mode, 7, "R13 timed out");
    rd(11'h700, 8'hA0, 2, "R14 timeout status");
    wr(11'h000, 8'h90);
    chk(dev_mode, 7, "R8 other write ignored");
    wr(11'h000, 8'hF0);
    chk(dev_mode, 0, "R8 reset leaves timeout");
    stall_inj = 1'b0;
    rd(11'h700, 8'hFF, 0, "R13 no write");

    repeat (4) @(negedge clk);
    chk(q_exp.size(), 0, "scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule